// File: doc/BRIEF.md
# Shelving Reservation Station with Dataflow Dispatch

This block is a central holding buffer between an in-order issue stage and a single execution unit. Each cycle it can take up to two decoded three-operand instructions (operation code, destination register, two source registers). When it accepts an instruction it reads both sources from a register file that keeps one availability bit per register. A source whose register is available is stored as a value. A source whose register still waits for a result is stored as a pending tag, which is the register number. The register file, its availability bits and the entry storage all sit inside the block.

Results come back on one write-back bus that carries a destination register number and a value. The bus writes the register file and makes the register available again. Every waiting entry whose pending tag equals the bus register takes the value. An entry is executable once both of its operands hold values. Each cycle, at most one executable entry is sent to the execution unit. The oldest executable entry always wins. A mode input chooses between strict in-order dispatch and dispatch that lets younger ready entries pass an older waiting one.

The block tracks each register by its number only. The issue stage must therefore never have two writers of the same register outstanding at once. Writing a register that is already available is allowed, and it is how software loads initial values.

Top module: `rs_shelf`

## Requirements
- R1: When an instruction is accepted, a source register marked available is captured as a value. The value comes from the register file, or from the write-back bus if that bus writes the same register in that cycle.
- R2: A write-back in the same cycle that an instruction is accepted fills any source of that instruction naming the written register. The instruction can then dispatch in the next cycle without waiting.
- R3: `iss_stall` is high exactly when the number of asserted `iss_valid` bits exceeds the free entries (DEPTH minus occupied entries at the start of the cycle). When it is high, no instruction of that cycle is accepted. Occupancy never exceeds DEPTH.
- R4: Accepting an instruction marks its destination register unavailable. A write-back marks its register available and stores the value. If both happen to the same register in one cycle, the register ends up unavailable.
- R5: Slot 0 is older than slot 1. If slot 1 reads the register that slot 0 of the same cycle writes, that source of slot 1 is pending until the write-back of that register.
- R6: An entry is dispatched only when both of its operands hold values.
- R7: A write-back whose register equals an entry's pending tag fills that operand. The entry can dispatch in the cycle after the write-back.
- R8: With `ooo_mode` = 1, the dispatched entry is the oldest entry whose operands are both ready, even if an older entry is still waiting.
- R9: With `ooo_mode` = 0, only the oldest entry may dispatch. While it waits, no younger entry dispatches.
- R10: At most one entry dispatches per cycle. `disp_valid` and the `disp_*` fields are driven from the stored state in the cycle the entry is selected, and the entry is freed at the following edge.
- R11: After reset the station is empty, `disp_valid` and `iss_stall` are low, every register is available, and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ooo_mode | input | 1 | 1: younger ready entries may pass older ones; 0: strict order |
| iss_valid | input | ISSUE_W | Per-slot instruction present; slot 0 is oldest |
| iss_op | input | ISSUE_W x OP_W | Operation code per slot |
| iss_dst | input | ISSUE_W x TAG_W | Destination register per slot |
| iss_src_a | input | ISSUE_W x TAG_W | First source register per slot |
| iss_src_b | input | ISSUE_W x TAG_W | Second source register per slot |
| iss_stall | output | 1 | Presented instructions do not fit; none accepted |
| wb_valid | input | 1 | Write-back bus carries a result |
| wb_tag | input | TAG_W | Register written by the result |
| wb_data | input | DATA_W | Result value |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_op | output | OP_W | Operation code of the dispatched entry |
| disp_dst | output | TAG_W | Destination register of the dispatched entry |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |

## Verification
`iss_stall` depends on the current inputs, so it is due in the same cycle as the request. An accepted instruction with ready operands shows on the `disp_*` outputs in the cycle after its accepting edge. A pending operand that is filled at a write-back edge makes its entry eligible in the cycle after that edge. The bench drives every input at the falling edge and samples outputs one time step later. It compares all outputs against a behavioural queue model that advances once per rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/rs_shelf_pkg.sv
package rs_shelf_pkg;

    typedef enum logic {
        MODE_IN_ORDER     = 1'b0,
        MODE_OUT_OF_ORDER = 1'b1
    } disp_mode_e;

    function automatic int count_set(input logic [31:0] bits);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(bits[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rs_shelf_regfile.sv
module rs_shelf_regfile #(
    parameter int NREGS   = 16,
    parameter int DATA_W  = 16,
    parameter int ISSUE_W = 2,
    localparam int TAG_W  = $clog2(NREGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wb_valid,
    input  logic [TAG_W-1:0]                  wb_tag,
    input  logic [DATA_W-1:0]                 wb_data,
    input  logic [ISSUE_W-1:0]                acc,
    input  logic [ISSUE_W-1:0][TAG_W-1:0]     dst,
    input  logic [ISSUE_W-1:0][TAG_W-1:0]     src_a,
    input  logic [ISSUE_W-1:0][TAG_W-1:0]     src_b,
    output logic [ISSUE_W-1:0]                a_rdy,
    output logic [ISSUE_W-1:0]                b_rdy,
    output logic [ISSUE_W-1:0][DATA_W-1:0]    a_val,
    output logic [ISSUE_W-1:0][DATA_W-1:0]    b_val,
    output logic [NREGS-1:0]                  avail
);

    typedef struct packed {
        logic [NREGS-1:0][DATA_W-1:0] data;
        logic [NREGS-1:0]             avail;
    } rf_t;

    rf_t st_d, st_q;

    // Read one source: older-slot hazard, then bus forward, then stored value.
    function automatic logic [DATA_W:0] fetch(
        input logic [TAG_W-1:0]  r,
        input logic              hazard,
        input rf_t               st,
        input logic              bus_v,
        input logic [TAG_W-1:0]  bus_t,
        input logic [DATA_W-1:0] bus_d
    );
        logic [DATA_W:0] res;
        res = '0;
        if (hazard) begin
            res = '0;
        end else if (bus_v && bus_t == r) begin
            res = {1'b1, bus_d};
        end else if (st.avail[r]) begin
            res = {1'b1, st.data[r]};
        end
        return res;
    endfunction

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_port
        logic            haz_a, haz_b;
        logic [DATA_W:0] rd_a, rd_b;

        always_comb begin
            haz_a = 1'b0;
            haz_b = 1'b0;
            for (int j = 0; j < s; j++) begin
                if (acc[j] && dst[j] == src_a[s]) haz_a = 1'b1;
                if (acc[j] && dst[j] == src_b[s]) haz_b = 1'b1;
            end
            rd_a = fetch(src_a[s], haz_a, st_q, wb_valid, wb_tag, wb_data);
            rd_b = fetch(src_b[s], haz_b, st_q, wb_valid, wb_tag, wb_data);
        end

        assign a_rdy[s] = rd_a[DATA_W];
        assign a_val[s] = rd_a[DATA_W-1:0];
        assign b_rdy[s] = rd_b[DATA_W];
        assign b_val[s] = rd_b[DATA_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (wb_valid) begin
            st_d.data[wb_tag]  = wb_data;
            st_d.avail[wb_tag] = 1'b1;
        end
        for (int s = 0; s < ISSUE_W; s++) begin
            if (acc[s]) st_d.avail[dst[s]] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.avail <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail = st_q.avail;

endmodule

// File: rtl/rs_shelf_select.sv
module rs_shelf_select #(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] ready,
    input  logic             ooo_mode,
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_idx
);
    import rs_shelf_pkg::*;

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] first;
    logic [DEPTH:0]   seen;

    // Strict order: only the head (index 0, the oldest) may be picked.
    assign elig = (disp_mode_e'(ooo_mode) == MODE_OUT_OF_ORDER)
                ? ready
                : {{(DEPTH-1){1'b0}}, ready[0]};

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < DEPTH; i++) begin : g_chain
        assign first[i]  = elig[i] & ~seen[i];
        assign seen[i+1] = seen[i] | elig[i];
    end

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (first[i]) sel_idx = IDX_W'(i);
        end
    end

    assign sel_valid = seen[DEPTH];

endmodule

// File: rtl/rs_shelf.sv
module rs_shelf #(
    parameter int DEPTH   = 8,
    parameter int NREGS   = 16,
    parameter int DATA_W  = 16,
    parameter int OP_W    = 3,
    parameter int ISSUE_W = 2,
    localparam int TAG_W  = $clog2(NREGS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ooo_mode,
    input  logic [ISSUE_W-1:0]            iss_valid,
    input  logic [ISSUE_W-1:0][OP_W-1:0]  iss_op,
    input  logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst,
    input  logic [ISSUE_W-1:0][TAG_W-1:0] iss_src_a,
    input  logic [ISSUE_W-1:0][TAG_W-1:0] iss_src_b,
    output logic                          iss_stall,
    input  logic                          wb_valid,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_data,
    output logic                          disp_valid,
    output logic [OP_W-1:0]               disp_op,
    output logic [TAG_W-1:0]              disp_dst,
    output logic [DATA_W-1:0]             disp_a,
    output logic [DATA_W-1:0]             disp_b
);
    import rs_shelf_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic              a_rdy;
        logic [TAG_W-1:0]  a_tag;
        logic [DATA_W-1:0] a_val;
        logic              b_rdy;
        logic [TAG_W-1:0]  b_tag;
        logic [DATA_W-1:0] b_val;
    } ent_t;

    // Entries are kept compacted: index 0 is always the oldest.
    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] count;
    } shelf_t;

    shelf_t st_d, st_q;

    logic [ISSUE_W-1:0]             acc;
    logic [ISSUE_W-1:0]             rd_a_rdy, rd_b_rdy;
    logic [ISSUE_W-1:0][DATA_W-1:0] rd_a_val, rd_b_val;
    logic [NREGS-1:0]               reg_avail;
    logic [DEPTH-1:0]               ready;
    logic                           sel_valid;
    logic [IDX_W-1:0]               sel_idx;
    logic [CNT_W-1:0]               occupancy;
    ent_t                           fresh [ISSUE_W];
    ent_t                           head;

    // Admission: all-or-nothing against the free space at cycle start.
    always_comb begin
        int nreq;
        nreq      = count_set(32'(iss_valid));
        iss_stall = nreq > (DEPTH - int'(st_q.count));
        acc       = iss_stall ? '0 : iss_valid;
    end

    rs_shelf_regfile #(
        .NREGS  (NREGS),
        .DATA_W (DATA_W),
        .ISSUE_W(ISSUE_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_valid(wb_valid),
        .wb_tag  (wb_tag),
        .wb_data (wb_data),
        .acc     (acc),
        .dst     (iss_dst),
        .src_a   (iss_src_a),
        .src_b   (iss_src_b),
        .a_rdy   (rd_a_rdy),
        .b_rdy   (rd_b_rdy),
        .a_val   (rd_a_val),
        .b_val   (rd_b_val),
        .avail   (reg_avail)
    );

    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            fresh[s].valid = 1'b1;
            fresh[s].op    = iss_op[s];
            fresh[s].dst   = iss_dst[s];
            fresh[s].a_rdy = rd_a_rdy[s];
            fresh[s].a_tag = iss_src_a[s];
            fresh[s].a_val = rd_a_val[s];
            fresh[s].b_rdy = rd_b_rdy[s];
            fresh[s].b_tag = iss_src_b[s];
            fresh[s].b_val = rd_b_val[s];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ready
        assign ready[i] = st_q.ent[i].valid & st_q.ent[i].a_rdy & st_q.ent[i].b_rdy;
    end

    rs_shelf_select #(
        .DEPTH(DEPTH)
    ) u_select (
        .ready    (ready),
        .ooo_mode (ooo_mode),
        .sel_valid(sel_valid),
        .sel_idx  (sel_idx)
    );

    always_comb begin
        ent_t [DEPTH:0] wk;
        int slot;
        st_d = st_q;
        // Wakeup of waiting operands from the result bus.
        for (int i = 0; i < DEPTH; i++) begin
            wk[i] = st_q.ent[i];
            if (wb_valid && wk[i].valid) begin
                if (!wk[i].a_rdy && wk[i].a_tag == wb_tag) begin
                    wk[i].a_rdy = 1'b1;
                    wk[i].a_val = wb_data;
                end
                if (!wk[i].b_rdy && wk[i].b_tag == wb_tag) begin
                    wk[i].b_rdy = 1'b1;
                    wk[i].b_val = wb_data;
                end
            end
        end
        wk[DEPTH] = '0;
        // Remove the dispatched entry and close the gap.
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_valid && i >= int'(sel_idx)) st_d.ent[i] = wk[i+1];
            else                                  st_d.ent[i] = wk[i];
        end
        // Append accepted instructions behind the survivors, oldest slot first.
        slot = int'(st_q.count) - int'(sel_valid);
        for (int s = 0; s < ISSUE_W; s++) begin
            if (acc[s]) begin
                if (slot < DEPTH) st_d.ent[IDX_W'(slot)] = fresh[s];
                slot++;
            end
        end
        st_d.count = CNT_W'(slot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occupancy  = st_q.count;
    assign head       = st_q.ent[sel_idx];
    assign disp_valid = sel_valid;
    assign disp_op    = head.op;
    assign disp_dst   = head.dst;
    assign disp_a     = head.a_val;
    assign disp_b     = head.b_val;

endmodule

// File: rtl/rs_shelf_chk.sv
module rs_shelf_chk #(
    parameter int DEPTH   = 8,
    parameter int NREGS   = 16,
    parameter int ISSUE_W = 2,
    localparam int TAG_W  = $clog2(NREGS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ooo_mode,
    input logic [ISSUE_W-1:0]            iss_valid,
    input logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst,
    input logic                          iss_stall,
    input logic                          wb_valid,
    input logic [TAG_W-1:0]              wb_tag,
    input logic                          disp_valid,
    input logic [IDX_W-1:0]              sel_idx,
    input logic [CNT_W-1:0]              occupancy,
    input logic [NREGS-1:0]              reg_avail
);

    logic wb_clash;
    always_comb begin
        wb_clash = 1'b0;
        for (int s = 0; s < ISSUE_W; s++) begin
            if (iss_valid[s] && !iss_stall && iss_dst[s] == wb_tag) wb_clash = 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    assert_stall_accepts_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |=> occupancy == $past(occupancy) - CNT_W'($past(disp_valid)));

    assert_strict_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !ooo_mode) |-> sel_idx == '0);

    assert_dispatch_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && iss_valid == '0) |=> occupancy == $past(occupancy) - 1'b1);

    assert_wb_sets_avail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_clash) |=> reg_avail[$past(wb_tag)]);

    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        assert_issue_clears_avail_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[s] && !iss_stall) |=> !reg_avail[$past(iss_dst[s])]);
    end

endmodule

bind rs_shelf rs_shelf_chk #(
    .DEPTH  (DEPTH),
    .NREGS  (NREGS),
    .ISSUE_W(ISSUE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ooo_mode  (ooo_mode),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .iss_stall (iss_stall),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .disp_valid(disp_valid),
    .sel_idx   (sel_idx),
    .occupancy (occupancy),
    .reg_avail (reg_avail)
);

// File: tb/tb_rs_shelf.sv
module tb_rs_shelf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int NREGS = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ooo_mode = 1'b1;
    logic [1:0]      iss_valid = '0;
    logic [1:0][2:0] iss_op = '0;
    logic [1:0][3:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic            iss_stall;
    logic            wb_valid = 1'b0;
    logic [3:0]      wb_tag = '0;
    logic [15:0]     wb_data = '0;
    logic            disp_valid;
    logic [2:0]      disp_op;
    logic [3:0]      disp_dst;
    logic [15:0]     disp_a, disp_b;

    rs_shelf dut (
        .clk(clk), .rst_n(rst_n), .ooo_mode(ooo_mode),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_stall(iss_stall),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_a(disp_a), .disp_b(disp_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          op;
        int          dst;
        bit          av;
        int          at;
        logic [15:0] ad;
        bit          bv;
        int          bt;
        logic [15:0] bd;
    } me_t;

    typedef struct {
        int          t;
        logic [15:0] d;
        int          dl;
    } eu_t;

    me_t         mq[$];
    eu_t         euq[$];
    logic [15:0] mrf[NREGS];
    bit          msb[NREGS];
    bit          m_acc[2];

    int          g_iv[2], g_op[2], g_d[2], g_a[2], g_b[2];
    bit          g_wbv;
    int          g_wbt;
    logic [15:0] g_wbd;
    bit          g_ooo = 1'b1;
    bit          auto_eu = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_iss(input int s, input int op, input int d, input int a, input int b);
        g_iv[s] = 1; g_op[s] = op; g_d[s] = d; g_a[s] = a; g_b[s] = b;
    endtask

    task automatic set_wb(input int t, input logic [15:0] v);
        g_wbv = 1'b1; g_wbt = t; g_wbd = v;
    endtask

    task automatic mread(input int s, input int r, output bit v, output logic [15:0] d);
        v = 1'b0; d = '0;
        if (s == 1 && m_acc[0] && g_d[0] == r) v = 1'b0;
        else if (g_wbv && g_wbt == r) begin v = 1'b1; d = g_wbd; end
        else if (msb[r]) begin v = 1'b1; d = mrf[r]; end
    endtask

    task automatic tick(input string req);
        int  exp_idx;
        bit  exp_stall;
        me_t ne;
        @(negedge clk);
        ooo_mode = g_ooo;
        for (int s = 0; s < 2; s++) begin
            iss_valid[s] = (g_iv[s] != 0);
            iss_op[s]    = 3'(g_op[s]);
            iss_dst[s]   = 4'(g_d[s]);
            iss_src_a[s] = 4'(g_a[s]);
            iss_src_b[s] = 4'(g_b[s]);
        end
        wb_valid = g_wbv; wb_tag = 4'(g_wbt); wb_data = g_wbd;
        #1;
        exp_stall = (mq.size() + g_iv[0] + g_iv[1]) > DEPTH;
        exp_idx = -1;
        if (g_ooo) begin
            for (int i = 0; i < mq.size(); i++)
                if (exp_idx < 0 && mq[i].av && mq[i].bv) exp_idx = i;
        end else if (mq.size() > 0 && mq[0].av && mq[0].bv) begin
            exp_idx = 0;
        end
        check("R3", "iss_stall", iss_stall, exp_stall);
        check(req, "disp_valid", disp_valid, exp_idx >= 0);
        if (exp_idx >= 0 && disp_valid) begin
            check(req, "disp_op",  disp_op,  mq[exp_idx].op);
            check(req, "disp_dst", disp_dst, mq[exp_idx].dst);
            check(req, "disp_a",   disp_a,   mq[exp_idx].ad);
            check(req, "disp_b",   disp_b,   mq[exp_idx].bd);
        end
        // Advance the model by one rising edge.
        for (int s = 0; s < 2; s++) m_acc[s] = g_iv[s] != 0 && !exp_stall;
        if (exp_idx >= 0) begin
            if (auto_eu) begin
                eu_t r;
                r.t = mq[exp_idx].dst;
                r.d = 16'(mq[exp_idx].ad + mq[exp_idx].bd + 16'(mq[exp_idx].op));
                r.dl = int'($urandom % 3);
                euq.push_back(r);
            end
            mq.delete(exp_idx);
        end
        if (g_wbv) begin
            for (int i = 0; i < mq.size(); i++) begin
                me_t t = mq[i];
                if (!t.av && t.at == g_wbt) begin t.av = 1'b1; t.ad = g_wbd; end
                if (!t.bv && t.bt == g_wbt) begin t.bv = 1'b1; t.bd = g_wbd; end
                mq[i] = t;
            end
        end
        for (int s = 0; s < 2; s++) begin
            if (m_acc[s]) begin
                ne.op = g_op[s]; ne.dst = g_d[s]; ne.at = g_a[s]; ne.bt = g_b[s];
                mread(s, g_a[s], ne.av, ne.ad);
                mread(s, g_b[s], ne.bv, ne.bd);
                mq.push_back(ne);
            end
        end
        if (g_wbv) begin mrf[g_wbt] = g_wbd; msb[g_wbt] = 1'b1; end
        for (int s = 0; s < 2; s++) if (m_acc[s]) msb[g_d[s]] = 1'b0;
        for (int s = 0; s < 2; s++) begin g_iv[s] = 0; g_op[s] = 0; g_d[s] = 0; g_a[s] = 0; g_b[s] = 0; end
        g_wbv = 1'b0; g_wbt = 0; g_wbd = '0;
    endtask

    task automatic eu_emit();
        int idx = -1;
        for (int i = 0; i < euq.size(); i++) begin
            if (idx < 0 && euq[i].dl <= 0) idx = i;
            else euq[i].dl = euq[i].dl - 1;
        end
        if (idx >= 0) begin
            set_wb(euq[idx].t, euq[idx].d);
            euq.delete(idx);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < NREGS; r++) begin mrf[r] = '0; msb[r] = 1'b1; end
        for (int s = 0; s < 2; s++) begin g_iv[s] = 0; g_op[s] = 0; g_d[s] = 0; g_a[s] = 0; g_b[s] = 0; end
        g_wbv = 1'b0; g_wbt = 0; g_wbd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11", "disp_valid after reset", disp_valid, 0);
        check("R11", "iss_stall after reset", iss_stall, 0);

        // R11: registers read as zero and available after reset.
        set_iss(0, 2, 10, 11, 12); tick("R11");
        tick("R11");
        set_wb(10, 16'h0); tick("R4");
        // Load initial values through the bus.
        set_wb(1, 16'd5); tick("R4");
        set_wb(2, 16'd7); tick("R4");
        set_wb(3, 16'd100); tick("R4");
        // R1: captured values.
        set_iss(0, 1, 4, 1, 2); tick("R1");
        tick("R1");
        set_wb(4, 16'd12); tick("R4");
        // R5 / R7: slot 1 depends on slot 0 of the same cycle.
        set_iss(0, 1, 5, 1, 2); set_iss(1, 3, 6, 5, 3); tick("R5");
        tick("R5");
        tick("R6");
        set_wb(5, 16'h55); tick("R7");
        tick("R7");
        set_wb(6, 16'h1); tick("R4");
        // R2: forward of a same-cycle write-back into a new entry.
        set_iss(0, 4, 8, 1, 1); tick("R2");
        tick("R2");
        set_wb(8, 16'h88); set_iss(0, 5, 9, 8, 2); tick("R2");
        tick("R2");
        set_wb(9, 16'h9); tick("R4");
        // R8: younger ready entry passes an older waiting one.
        set_iss(0, 6, 11, 1, 1); tick("R8");
        tick("R8");
        set_iss(0, 7, 12, 11, 1); tick("R8");
        set_iss(0, 2, 13, 2, 3); tick("R8");
        tick("R8");
        tick("R8");
        set_wb(11, 16'h1111); tick("R8");
        tick("R8");
        set_wb(12, 16'h12); tick("R4");
        set_wb(13, 16'h13); tick("R4");
        // R9: strict order blocks behind the head.
        g_ooo = 1'b0;
        set_iss(0, 6, 11, 1, 1); tick("R9");
        tick("R9");
        set_iss(0, 7, 12, 11, 1); tick("R9");
        set_iss(0, 2, 13, 2, 3); tick("R9");
        tick("R9");
        tick("R9");
        tick("R9");
        set_wb(11, 16'h2222); tick("R9");
        tick("R9");
        tick("R9");
        tick("R9");
        set_wb(12, 16'h21); tick("R4");
        set_wb(13, 16'h22); tick("R4");
        // R3: fill the station and present more than fits.
        g_ooo = 1'b1;
        set_iss(0, 1, 14, 1, 1); tick("R3");
        tick("R3");
        set_iss(0, 1, 0, 14, 14); set_iss(1, 2, 15, 14, 1); tick("R3");
        set_iss(0, 3, 4, 14, 2); set_iss(1, 4, 5, 3, 14); tick("R3");
        set_iss(0, 5, 6, 14, 14); set_iss(1, 6, 7, 14, 14); tick("R3");
        set_iss(0, 7, 8, 14, 1); tick("R3");
        set_iss(0, 1, 9, 1, 2); set_iss(1, 2, 10, 1, 2); tick("R3");
        set_iss(0, 1, 9, 14, 2); tick("R3");
        set_iss(0, 2, 10, 1, 2); tick("R3");
        set_wb(14, 16'h4444); tick("R7");
        for (int k = 0; k < 10; k++) tick("R10");
        for (int r = 0; r < NREGS; r++) begin set_wb(r, 16'(r * 3 + 1)); tick("R4"); end

        // Mixed traffic with the bench acting as the execution unit.
        auto_eu = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) g_ooo = ~g_ooo;
            eu_emit();
            for (int s = 0; s < 2; s++) begin
                if ($urandom % 3 != 0) begin
                    int r = int'($urandom % NREGS);
                    if (msb[r] && !(s == 1 && g_iv[0] != 0 && g_d[0] == r))
                        set_iss(s, int'($urandom % 8), r, int'($urandom % NREGS), int'($urandom % NREGS));
                end
            end
            tick(g_ooo ? "R8" : "R9");
        end
        for (int c = 0; c < 100; c++) begin
            eu_emit();
            tick("R10");
        end
        done = 1'b1;
        finish_run();
    end

endmodule